// File: doc/BRIEF.md
# Timed Configuration-Byte Readback Unit

This unit sits next to the program-memory load path of a small processor. Software writes an arming pattern into a self-programming control register. That write opens a short window, counted in clock cycles. If a program-memory load arrives while the window is open, the load returns a stored configuration byte in place of flash contents. Depending on the pattern written, that byte is a fuse byte, the lock byte or a signature byte.

The byte returned is chosen by the 16-bit pointer. The arming bits clear themselves when a configuration read completes, when a store instruction arrives, or when the window runs out. After that, loads return flash data again.

The controller has three states:

- `S_IDLE`: the unit is disarmed.
- `S_LOCK`: fuse and lock readback is armed.
- `S_SIG`: signature readback is armed.

The named transitions are:

- `arm_lock`: S_IDLE or any armed state goes to S_LOCK.
- `arm_sig`: S_IDLE or any armed state goes to S_SIG.
- `disarm_write`: a control write that carries no valid pattern goes to S_IDLE.
- `complete`: a load while armed goes to S_IDLE.
- `store_abort`: a store while armed goes to S_IDLE.
- `expire`: the window runs out and the state goes to S_IDLE.

Top module: `cfg_readback`

## Requirements
- R1: A synchronous active-high reset sets `ctl_bits` to 0x00 and `rd_data` to 0x00.
- R2: Control bit positions are enable = bit 0, lock-read arm = bit 3 and signature-read arm = bit 5.
  - A write of enable plus lock-read arm sets `ctl_bits` to 0x09 on the next cycle.
  - A write of enable plus signature-read arm sets `ctl_bits` to 0x21 on the next cycle.
- R3: In lock mode, a load captures a byte into `rd_data` at the clock edge of the load. The pointer selects the byte as follows:
  - 0x0000 gives `fuse_lo`.
  - 0x0001 gives {2'b11, `lock_bits`}.
  - 0x0002 gives {4'hF, `fuse_ext`}.
  - 0x0003 gives `fuse_hi`.
  - Any other pointer gives 0xFF.
  - Stored bits pass through unchanged, so a programmed bit (stored 0) reads 0 and an unprogrammed bit reads 1.
- R4: In signature mode, pointer 0x0000, 0x0002 and 0x0004 return `sig_bytes[7:0]`, `[15:8]` and `[23:16]` respectively. Any other pointer returns 0xFF.
- R5: A load accepted in an armed state clears `ctl_bits` to 0x00 on the same edge.
- R6: The window is three cycles long and starts on the cycle after the arming write.
  - A load in the third cycle after the write is still redirected.
  - With no load or store in those three cycles, `ctl_bits` is 0x00 afterwards.
  - A load after that returns flash data.
- R7: A store strobe while armed clears `ctl_bits` to 0x00 and returns no configuration data. The following load returns flash data.
- R8: While disarmed, a load registers `flash_data` into `rd_data`.
- R9: A write that sets both arm bits together with enable selects signature mode, so `ctl_bits` becomes 0x21.
- R10: An arming write while already armed restarts the three-cycle window.
- R11: A control write without enable, or with enable but no arm bit, leaves the unit disarmed, and `ctl_bits` reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ld_strobe | input | 1 | Program-memory load issued this cycle |
| st_strobe | input | 1 | Store-to-program-memory issued this cycle |
| zptr | input | 16 | Pointer register |
| flash_data | input | 8 | Normal flash read data |
| fuse_lo | input | 8 | Stored low fuse byte |
| fuse_hi | input | 8 | Stored high fuse byte |
| fuse_ext | input | 4 | Stored extended fuse bits |
| lock_bits | input | 6 | Stored lock bits |
| sig_bytes | input | 24 | Signature bytes, byte 0 in the low bits |
| rd_data | output | 8 | Registered load result |
| ctl_bits | output | 8 | Live control register bits |

## Verification
A wrong controller state shows up on `ctl_bits` on the cycle after the edge that caused it, either as a value other than 0x00, 0x09 or 0x21, or as arm bits that fail to clear. An off-by-one in the window counter shows up at the very next load. A load in the third window cycle would return flash data, or a load in the fourth would still return a configuration byte, and `rd_data` would show the difference one edge after the load. A wrong pointer decode shows up in that same cycle as the wrong byte or a missing 0xFF.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOCK = 2'd1,
        S_SIG  = 2'd2
    } rb_state_e;

    localparam int BIT_EN   = 0;
    localparam int BIT_LOCK = 3;
    localparam int BIT_SIG  = 5;
endpackage

// File: rtl/rb_window_timer.sv
module rb_window_timer #(
    parameter int WINDOW = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(WINDOW + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(WINDOW - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (cnt != LAST_CNT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_CNT);
endmodule

// File: rtl/rb_byte_select.sv
module rb_byte_select #(
    parameter int SIG_BYTES = 3
) (
    input  logic                   mode_lock,
    input  logic                   mode_sig,
    input  logic [15:0]            zptr,
    input  logic [7:0]             flash_data,
    input  logic [7:0]             fuse_lo,
    input  logic [7:0]             fuse_hi,
    input  logic [3:0]             fuse_ext,
    input  logic [5:0]             lock_bits,
    input  logic [8*SIG_BYTES-1:0] sig_bytes,
    output logic [7:0]             sel_data
);
    logic [SIG_BYTES-1:0] sig_hit;
    logic [7:0]           sig_part [SIG_BYTES];
    logic [7:0]           sig_val;
    logic [7:0]           lock_val;

    for (genvar g = 0; g < SIG_BYTES; g++) begin : g_sig
        assign sig_hit[g]  = (zptr == 16'(2 * g));
        assign sig_part[g] = sig_hit[g] ? sig_bytes[8*g +: 8] : 8'h00;
    end

    always_comb begin
        sig_val = (sig_hit == '0) ? 8'hFF : 8'h00;
        for (int i = 0; i < SIG_BYTES; i++) begin
            sig_val = sig_val | sig_part[i];
        end
    end

    always_comb begin
        unique case (zptr)
            16'h0000: lock_val = fuse_lo;
            16'h0001: lock_val = {2'b11, lock_bits};
            16'h0002: lock_val = {4'hF, fuse_ext};
            16'h0003: lock_val = fuse_hi;
            default:  lock_val = 8'hFF;
        endcase
    end

    always_comb begin
        if (mode_sig) begin
            sel_data = sig_val;
        end else if (mode_lock) begin
            sel_data = lock_val;
        end else begin
            sel_data = flash_data;
        end
    end
endmodule

// File: rtl/cfg_readback.sv
module cfg_readback
    import cfg_readback_pkg::*;
#(
    parameter int WINDOW    = 3,
    parameter int SIG_BYTES = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ctl_we,
    input  logic [7:0]             ctl_wdata,
    input  logic                   ld_strobe,
    input  logic                   st_strobe,
    input  logic [15:0]            zptr,
    input  logic [7:0]             flash_data,
    input  logic [7:0]             fuse_lo,
    input  logic [7:0]             fuse_hi,
    input  logic [3:0]             fuse_ext,
    input  logic [5:0]             lock_bits,
    input  logic [8*SIG_BYTES-1:0] sig_bytes,
    output logic [7:0]             rd_data,
    output logic [7:0]             ctl_bits
);
    rb_state_e state, nxt;
    rb_state_e wr_target;
    logic      win_last;
    logic      restart;
    logic      armed;
    logic [7:0] sel_data;

    // Decode of a control write into the state it requests
    always_comb begin
        if (!ctl_wdata[BIT_EN]) begin
            wr_target = S_IDLE;
        end else if (ctl_wdata[BIT_SIG]) begin
            wr_target = S_SIG;   // arm_sig wins over arm_lock
        end else if (ctl_wdata[BIT_LOCK]) begin
            wr_target = S_LOCK;
        end else begin
            wr_target = S_IDLE;
        end
    end

    assign armed   = (state != S_IDLE);
    assign restart = ctl_we && (wr_target != S_IDLE);

    rb_window_timer #(.WINDOW(WINDOW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .run     (armed),
        .last    (win_last)
    );

    rb_byte_select #(.SIG_BYTES(SIG_BYTES)) u_sel (
        .mode_lock  (state == S_LOCK),
        .mode_sig   (state == S_SIG),
        .zptr       (zptr),
        .flash_data (flash_data),
        .fuse_lo    (fuse_lo),
        .fuse_hi    (fuse_hi),
        .fuse_ext   (fuse_ext),
        .lock_bits  (lock_bits),
        .sig_bytes  (sig_bytes),
        .sel_data   (sel_data)
    );

    // Next-state logic
    always_comb begin
        nxt = state;
        if (ctl_we) begin
            nxt = wr_target;                       // arm_lock / arm_sig / disarm_write
        end else begin
            unique case (state)
                S_IDLE: nxt = S_IDLE;
                S_LOCK, S_SIG: begin
                    if (ld_strobe || st_strobe || win_last) begin
                        nxt = S_IDLE;              // complete / store_abort / expire
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= 8'h00;
        end else if (ld_strobe) begin
            rd_data <= sel_data;
        end
    end

    always_comb begin
        ctl_bits = 8'h00;
        unique case (state)
            S_IDLE: ctl_bits = 8'h00;
            S_LOCK: begin
                ctl_bits[BIT_EN]   = 1'b1;
                ctl_bits[BIT_LOCK] = 1'b1;
            end
            S_SIG: begin
                ctl_bits[BIT_EN]  = 1'b1;
                ctl_bits[BIT_SIG] = 1'b1;
            end
            default: ctl_bits = 8'h00;
        endcase
    end
endmodule

// File: rtl/cfg_readback_chk.sv
module cfg_readback_chk #(
    parameter int WINDOW = 3
) (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic       ld_strobe,
    input logic       st_strobe,
    input logic [7:0] flash_data,
    input logic [7:0] rd_data,
    input logic [7:0] ctl_bits
);
    logic [7:0] armed_cnt;
    logic       seen_reset;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_reset <= 1'b1;
        end
        if (rst || ctl_we || ctl_bits == 8'h00) begin
            armed_cnt <= 8'h00;
        end else if (armed_cnt != 8'hFF) begin
            armed_cnt <= armed_cnt + 1'b1;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (ctl_bits == 8'h00 && rd_data == 8'h00));

    assert_legal_bits_R2: assert property (@(posedge clk) disable iff (rst || !seen_reset)
        (ctl_bits == 8'h00 || ctl_bits == 8'h09 || ctl_bits == 8'h21));

    assert_complete_clears_R5: assert property (@(posedge clk) disable iff (rst || !seen_reset)
        (ctl_bits != 8'h00 && ld_strobe && !ctl_we) |=> (ctl_bits == 8'h00));

    assert_window_limit_R6: assert property (@(posedge clk) disable iff (rst || !seen_reset)
        (ctl_bits != 8'h00) |-> (armed_cnt < 8'(WINDOW)));

    assert_store_abort_R7: assert property (@(posedge clk) disable iff (rst || !seen_reset)
        (ctl_bits != 8'h00 && st_strobe && !ctl_we) |=> (ctl_bits == 8'h00));

    assert_idle_flash_R8: assert property (@(posedge clk) disable iff (rst || !seen_reset)
        (ctl_bits == 8'h00 && ld_strobe) |=> (rd_data == $past(flash_data)));
endmodule

bind cfg_readback cfg_readback_chk #(.WINDOW(WINDOW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ld_strobe  (ld_strobe),
    .st_strobe  (st_strobe),
    .flash_data (flash_data),
    .rd_data    (rd_data),
    .ctl_bits   (ctl_bits)
);

// File: tb/test_cfg_readback.sv
module test_cfg_readback;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic        ld_strobe = 1'b0;
    logic        st_strobe = 1'b0;
    logic [15:0] zptr = 16'h0000;
    logic [7:0]  flash_data = 8'h5A;
    logic [7:0]  fuse_lo = 8'h62;
    logic [7:0]  fuse_hi = 8'hDF;
    logic [3:0]  fuse_ext = 4'b0110;
    logic [5:0]  lock_bits = 6'b101010;
    logic [23:0] sig_bytes = 24'h0A921E;
    logic [7:0]  rd_data;
    logic [7:0]  ctl_bits;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;

    cfg_readback i_cfg_readback (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ld_strobe(ld_strobe), .st_strobe(st_strobe), .zptr(zptr),
        .flash_data(flash_data), .fuse_lo(fuse_lo), .fuse_hi(fuse_hi),
        .fuse_ext(fuse_ext), .lock_bits(lock_bits), .sig_bytes(sig_bytes),
        .rd_data(rd_data), .ctl_bits(ctl_bits)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Monitor: compares each load result one edge after the load
    initial begin
        forever begin
            @(posedge clk);
            if (ld_strobe && !rst) begin
                #1;
                if (exp_q.size() == 0) begin
                    check8("scoreboard-empty", rd_data, 8'hXX);
                end else begin
                    check8(tag_q.pop_front(), rd_data, exp_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic ld(input logic [15:0] z, input logic [7:0] exp, input string tag);
        zptr = z;
        ld_strobe = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        ld_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
    end

    initial begin
        idle(3);
        rst = 1'b0;
        check8("R1 ctl_bits", ctl_bits, 8'h00);
        check8("R1 rd_data", rd_data, 8'h00);

        ld(16'h0010, 8'h5A, "R8 idle load");
        flash_data = 8'hC3;
        ld(16'h0000, 8'hC3, "R8 idle load 2");

        // Lock mode pointer map
        wr(8'h09);
        check8("R2 lock arm", ctl_bits, 8'h09);
        ld(16'h0000, 8'h62, "R3 fuse_lo");
        check8("R5 clear after load", ctl_bits, 8'h00);
        wr(8'h09); ld(16'h0001, 8'hEA, "R3 lock byte");
        wr(8'h09); ld(16'h0002, 8'hF6, "R3 ext fuse");
        wr(8'h09); ld(16'h0003, 8'hDF, "R3 fuse_hi");
        wr(8'h09); ld(16'h0007, 8'hFF, "R3 other addr");
        ld(16'h0003, 8'hC3, "R5 flash after complete");

        // Window length
        wr(8'h09); idle(2);
        check8("R6 still armed", ctl_bits, 8'h09);
        ld(16'h0003, 8'hDF, "R6 third cycle");
        wr(8'h09); idle(3);
        check8("R6 expired", ctl_bits, 8'h00);
        ld(16'h0003, 8'hC3, "R6 flash after expire");

        // Store abort
        wr(8'h09);
        st_strobe = 1'b1; @(negedge clk); st_strobe = 1'b0;
        check8("R7 store clears", ctl_bits, 8'h00);
        ld(16'h0000, 8'hC3, "R7 flash after store");

        // Signature mode
        wr(8'h21);
        check8("R2 sig arm", ctl_bits, 8'h21);
        ld(16'h0000, 8'h1E, "R4 sig0");
        wr(8'h21); ld(16'h0002, 8'h92, "R4 sig1");
        wr(8'h21); ld(16'h0004, 8'h0A, "R4 sig2");
        wr(8'h21); ld(16'h0001, 8'hFF, "R4 odd addr");
        wr(8'h21); ld(16'h0006, 8'hFF, "R4 beyond");

        // Priority
        wr(8'h29);
        check8("R9 sig priority", ctl_bits, 8'h21);
        ld(16'h0000, 8'h1E, "R9 sig data");

        // Restart
        wr(8'h09); idle(2); wr(8'h09); idle(2);
        check8("R10 restarted", ctl_bits, 8'h09);
        ld(16'h0000, 8'h62, "R10 load in restarted window");

        // Non-arming writes
        wr(8'h08);
        check8("R11 no enable", ctl_bits, 8'h00);
        ld(16'h0000, 8'hC3, "R11 flash no enable");
        wr(8'h01);
        check8("R11 enable only", ctl_bits, 8'h00);
        wr(8'h09); wr(8'h00);
        check8("R11 disarm write", ctl_bits, 8'h00);
        ld(16'h0001, 8'hC3, "R11 flash after disarm");

        idle(3);
        if (exp_q.size() != 0) check8("scoreboard-leftover", 8'(exp_q.size()), 8'h00);
        summary();
    end
endmodule